// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block is the datapath of a small accumulator machine in which every unit talks over a single 8-bit bus. It contains a program counter, a memory address register, an instruction register, two working registers A and B, a combinational adder/subtractor, a two-bit flags register (zero and carry) and a 16-byte RAM. A seventh bus source, an external data input, lets the surrounding logic place a value on the bus, for example to fill the RAM. The block does not sequence itself. On every beat an outside sequencer presents one set of driver enables and one set of capture enables, and the block carries out exactly that beat.

The bus is the bitwise OR of every enabled source. At most one source may drive on a beat. If two or more are enabled, the block raises a contention output during that beat. If none is enabled, the bus reads zero and a floating output is raised. Any number of destinations may capture the bus value on the same rising edge.

Top module: `sbus_datapath`

## Requirements
- R1: With exactly one driver enabled, `bus_q` equals that source's value. The driver bit indices are 0 PC, 1 IR, 2 RAM, 3 A, 4 B, 5 ALU and 6 external data. The 4-bit PC is zero-extended onto the bus.
- R2: With no driver enabled, `bus_q` is zero and `bus_float` is high in the same beat. Otherwise `bus_float` is low.
- R3: With two or more drivers enabled, `bus_conflict` is high in the same beat and `bus_q` is the bitwise OR of the enabled sources. Otherwise `bus_conflict` is low.
- R4: All capture enables asserted on a beat load the same bus value at the rising edge. The capture bit indices are 0 MAR, 1 IR, 2 RAM write, 3 A, 4 B and 5 PC jump. A register whose enable is low holds its value.
- R5: `pc_inc` advances the PC by one, wrapping from 15 to 0. This can happen on the same edge as an IR load. When the jump enable is also high, the PC takes the low 4 bits of the bus instead of incrementing.
- R6: The ALU output follows A, B and `alu_sub` within the beat. Its value is A+B, or A−B when `alu_sub` is high, modulo 256. Driving it while capturing into A stores that settled result at the edge.
- R7: When `flag_ld` is high, zero is set to (ALU result == 0) and carry is set to the adder carry-out. For subtraction, carry is 1 when no borrow occurs (A ≥ B). When `flag_ld` is low, both flags hold.
- R8: The IR driver places the IR's low nibble (the operand) on bus bits 3:0 and zeros on bits 7:4.
- R9: The RAM write enable stores the bus value at the address held in the MAR. The RAM driver presents the byte at that address.
- R10: A synchronous active-high reset clears PC, MAR, IR, A, B and both flags. RAM contents are not cleared.
- R11: The MAR loads the low 4 bits of the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| drv_en | input | 7 | Bus driver enables (PC, IR, RAM, A, B, ALU, external) |
| ld_en | input | 6 | Capture enables (MAR, IR, RAM write, A, B, PC jump) |
| pc_inc | input | 1 | Program counter count enable |
| flag_ld | input | 1 | Capture zero/carry from the ALU |
| alu_sub | input | 1 | ALU computes A−B instead of A+B |
| ext_data | input | 8 | Value driven by the external source |
| bus_q | output | 8 | Current bus value |
| bus_float | output | 1 | No driver enabled this beat |
| bus_conflict | output | 1 | More than one driver enabled this beat |
| pc_q | output | 4 | Program counter |
| mar_q | output | 4 | Memory address register |
| ir_q | output | 8 | Instruction register |
| a_q | output | 8 | Register A |
| b_q | output | 8 | Register B |
| zf_q | output | 1 | Zero flag |
| cf_q | output | 1 | Carry flag |

## Verification
The bus value and the floating and contention outputs are combinational in the enables, so they are due in the same beat. The bench therefore samples them one nanosecond after driving the inputs on the falling edge, well before the next rising edge. Register, RAM and flag updates are due one rising edge after the beat that requested them. The bench samples them one nanosecond after that edge, against a behavioural model that it advances on the same edge. The model's RAM is read back only through the RAM driver on a later beat, so a write is checked two beats after it is issued.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DW   = 8;
    localparam int AW   = 4;
    localparam int NDRV = 7;
    localparam int NLD  = 6;

    // bus driver indices
    localparam int DRV_PC  = 0;
    localparam int DRV_IR  = 1;
    localparam int DRV_RAM = 2;
    localparam int DRV_A   = 3;
    localparam int DRV_B   = 4;
    localparam int DRV_ALU = 5;
    localparam int DRV_EXT = 6;

    // capture indices
    localparam int LD_MAR = 0;
    localparam int LD_IR  = 1;
    localparam int LD_RAM = 2;
    localparam int LD_A   = 3;
    localparam int LD_B   = 4;
    localparam int LD_PC  = 5;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          zero;
        logic          carry;
    } alu_t;

    function automatic alu_t alu_eval(input logic [DW-1:0] a,
                                      input logic [DW-1:0] b,
                                      input logic          sub);
        logic [DW:0] w;
        alu_t        r;
        if (sub)
            w = {1'b0, a} + {1'b0, ~b} + (DW+1)'(1);
        else
            w = {1'b0, a} + {1'b0, b};
        r.res   = w[DW-1:0];
        r.carry = w[DW];
        r.zero  = (w[DW-1:0] == '0);
        return r;
    endfunction
endpackage

// File: rtl/sbus_bus.sv
module sbus_bus #(
    parameter int N = 7,
    parameter int W = 8
) (
    input  logic [N-1:0][W-1:0] src,
    input  logic [N-1:0]        en,
    output logic [W-1:0]        val,
    output logic                floating,
    output logic                conflict
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW = $clog2(N + 1);

    logic [W-1:0] acc [N+1];
    assign acc[0] = '0;

    for (genvar g = 0; g < N; g++) begin : g_or
        assign acc[g+1] = acc[g] | (en[g] ? src[g] : '0);
    end

    logic [CW-1:0] cnt;
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++)
            cnt = cnt + CW'(en[i]);
    end

    assign val      = acc[N];
    assign floating = (cnt == '0);
    assign conflict = (cnt > CW'(1));
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output alu_t          out
);
    timeunit 1ns;
    timeprecision 100ps;

    always_comb out = alu_eval(a, b, sub);
endmodule

// File: rtl/sbus_ram.sv
module sbus_ram #(
    parameter int W = 8,
    parameter int A = 4
) (
    input  logic         clk,
    input  logic         we,
    input  logic [A-1:0] addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DEPTH = 1 << A;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NDRV-1:0] drv_en,
    input  logic [NLD-1:0]  ld_en,
    input  logic            pc_inc,
    input  logic            flag_ld,
    input  logic            alu_sub,
    input  logic [DW-1:0]   ext_data,
    output logic [DW-1:0]   bus_q,
    output logic            bus_float,
    output logic            bus_conflict,
    output logic [AW-1:0]   pc_q,
    output logic [AW-1:0]   mar_q,
    output logic [DW-1:0]   ir_q,
    output logic [DW-1:0]   a_q,
    output logic [DW-1:0]   b_q,
    output logic            zf_q,
    output logic            cf_q
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int PADW = DW - AW;

    logic [NDRV-1:0][DW-1:0] src;
    logic [DW-1:0]           ram_rd;
    alu_t                    alu_o;

    assign src[DRV_PC]  = {{PADW{1'b0}}, pc_q};
    assign src[DRV_IR]  = {{PADW{1'b0}}, ir_q[AW-1:0]};
    assign src[DRV_RAM] = ram_rd;
    assign src[DRV_A]   = a_q;
    assign src[DRV_B]   = b_q;
    assign src[DRV_ALU] = alu_o.res;
    assign src[DRV_EXT] = ext_data;

    sbus_bus #(.N(NDRV), .W(DW)) i_bus (
        .src      (src),
        .en       (drv_en),
        .val      (bus_q),
        .floating (bus_float),
        .conflict (bus_conflict)
    );

    sbus_alu i_alu (
        .a   (a_q),
        .b   (b_q),
        .sub (alu_sub),
        .out (alu_o)
    );

    sbus_ram #(.W(DW), .A(AW)) i_ram (
        .clk   (clk),
        .we    (ld_en[LD_RAM]),
        .addr  (mar_q),
        .wdata (bus_q),
        .rdata (ram_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            zf_q  <= 1'b0;
            cf_q  <= 1'b0;
        end else begin
            if (ld_en[LD_MAR]) mar_q <= bus_q[AW-1:0];
            if (ld_en[LD_IR])  ir_q  <= bus_q;
            if (ld_en[LD_A])   a_q   <= bus_q;
            if (ld_en[LD_B])   b_q   <= bus_q;
            if (ld_en[LD_PC])  pc_q  <= bus_q[AW-1:0];
            else if (pc_inc)   pc_q  <= pc_q + AW'(1);
            if (flag_ld) begin
                zf_q <= alu_o.zero;
                cf_q <= alu_o.carry;
            end
        end
    end
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk
    import sbus_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NDRV-1:0] drv_en,
    input logic [NLD-1:0]  ld_en,
    input logic            pc_inc,
    input logic            flag_ld,
    input logic [DW-1:0]   ext_data,
    input logic [DW-1:0]   bus_q,
    input logic            bus_float,
    input logic            bus_conflict,
    input logic [AW-1:0]   pc_q,
    input logic [DW-1:0]   a_q,
    input logic            zf_q,
    input logic            cf_q
);
    timeunit 1ns;
    timeprecision 100ps;

    AST_EXT_SOLE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        (drv_en == NDRV'(1 << DRV_EXT)) |-> (bus_q == ext_data)); // R1

    AST_FLOAT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_float |-> (bus_q == '0 && !bus_conflict)); // R2

    AST_MULTI_DRIVER_FLAG: assert property (@(posedge clk) disable iff (rst)
        ($countones(drv_en) > 1) |-> bus_conflict); // R3

    AST_A_CAPTURES_BUS: assert property (@(posedge clk) disable iff (rst)
        ld_en[LD_A] |=> (a_q == $past(bus_q))); // R4

    AST_PC_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (pc_inc && !ld_en[LD_PC]) |=> (pc_q == AW'($past(pc_q) + AW'(1)))); // R5

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !flag_ld |=> $stable({zf_q, cf_q})); // R7

    AST_IR_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (drv_en == NDRV'(1 << DRV_IR)) |-> (bus_q[DW-1:AW] == '0)); // R8
endmodule

bind sbus_datapath sbus_datapath_chk i_chk (.*);

// File: tb/test_sbus_datapath.sv
module test_sbus_datapath;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] drv_en = '0;
    logic [5:0] ld_en = '0;
    logic       pc_inc = 1'b0, flag_ld = 1'b0, alu_sub = 1'b0;
    logic [7:0] ext_data = '0;
    logic [7:0] bus_q, ir_q, a_q, b_q;
    logic       bus_float, bus_conflict, zf_q, cf_q;
    logic [3:0] pc_q, mar_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // behavioural reference state
    int m_pc, m_mar, m_ir, m_a, m_b, m_z, m_c;
    int m_mem [16];

    always #2.5 clk = ~clk;

    sbus_datapath i_sbus_datapath (
        .clk(clk), .rst(rst), .drv_en(drv_en), .ld_en(ld_en),
        .pc_inc(pc_inc), .flag_ld(flag_ld), .alu_sub(alu_sub),
        .ext_data(ext_data), .bus_q(bus_q), .bus_float(bus_float),
        .bus_conflict(bus_conflict), .pc_q(pc_q), .mar_q(mar_q),
        .ir_q(ir_q), .a_q(a_q), .b_q(b_q), .zf_q(zf_q), .cf_q(cf_q)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int alu_res(input int sub);
        return sub ? ((m_a - m_b) & 255) : ((m_a + m_b) & 255);
    endfunction

    function automatic int alu_carry(input int sub);
        return sub ? int'(m_a >= m_b) : int'((m_a + m_b) > 255);
    endfunction

    task automatic check_regs(input string tag);
        chk("R5",  {tag, " pc"},  int'(pc_q),  m_pc);
        chk("R11", {tag, " mar"}, int'(mar_q), m_mar);
        chk("R4",  {tag, " ir"},  int'(ir_q),  m_ir);
        chk("R4",  {tag, " a"},   int'(a_q),   m_a);
        chk("R4",  {tag, " b"},   int'(b_q),   m_b);
        chk("R7",  {tag, " z"},   int'(zf_q),  m_z);
        chk("R7",  {tag, " c"},   int'(cf_q),  m_c);
    endtask

    // one beat: drive on falling edge, check bus mid-beat, check state after rising edge
    task automatic beat(input string tag, input logic [6:0] d, input logic [5:0] l,
                        input bit inc, input bit fl, input bit sub, input logic [7:0] ext);
        int eb, cnt, res, car;
        string rq;
        @(negedge clk);
        drv_en = d; ld_en = l; pc_inc = inc; flag_ld = fl; alu_sub = sub; ext_data = ext;
        res = alu_res(sub);
        car = alu_carry(sub);
        eb = 0; cnt = 0;
        if (d[0]) begin eb |= m_pc;          cnt++; end
        if (d[1]) begin eb |= (m_ir & 15);   cnt++; end
        if (d[2]) begin eb |= m_mem[m_mar];  cnt++; end
        if (d[3]) begin eb |= m_a;           cnt++; end
        if (d[4]) begin eb |= m_b;           cnt++; end
        if (d[5]) begin eb |= res;           cnt++; end
        if (d[6]) begin eb |= int'(ext);     cnt++; end
        #1;
        if (cnt > 1)       rq = "R3";
        else if (cnt == 0) rq = "R2";
        else if (d[1])     rq = "R8";
        else if (d[2])     rq = "R9";
        else if (d[5])     rq = "R6";
        else               rq = "R1";
        chk(rq,   {tag, " bus"},      int'(bus_q), eb);
        chk("R2", {tag, " float"},    int'(bus_float), int'(cnt == 0));
        chk("R3", {tag, " conflict"}, int'(bus_conflict), int'(cnt > 1));
        @(posedge clk);
        if (l[2]) m_mem[m_mar] = eb;
        if (l[0]) m_mar = eb & 15;
        if (l[1]) m_ir = eb;
        if (l[3]) m_a = eb;
        if (l[4]) m_b = eb;
        if (l[5]) m_pc = eb & 15;
        else if (inc) m_pc = (m_pc + 1) & 15;
        if (fl) begin m_z = int'(res == 0); m_c = car; end
        #1;
        check_regs(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; drv_en = '0; ld_en = '0; pc_inc = 0; flag_ld = 0; alu_sub = 0;
        @(posedge clk); #1;
        m_pc = 0; m_mar = 0; m_ir = 0; m_a = 0; m_b = 0; m_z = 0; m_c = 0;
        chk("R10", "reset pc",  int'(pc_q),  0);
        chk("R10", "reset mar", int'(mar_q), 0);
        chk("R10", "reset ir",  int'(ir_q),  0);
        chk("R10", "reset a",   int'(a_q),   0);
        chk("R10", "reset b",   int'(b_q),   0);
        chk("R10", "reset flags", int'({zf_q, cf_q}), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic poke(input int addr, input int val);
        beat("poke addr", 7'b1000000, 6'b000001, 0, 0, 0, 8'(addr)); // R11
        beat("poke data", 7'b1000000, 6'b000100, 0, 0, 0, 8'(val));  // R9
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        foreach (m_mem[i]) m_mem[i] = 0;
        repeat (2) @(posedge clk);
        do_reset(); // R10
        // fill RAM through the external driver (R9), all 16 cells known to the model
        for (int i = 0; i < 16; i++) poke(i, (i * 37 + 11) & 255);
        poke(0, 8'h35);  // instruction: operand 5
        poke(5, 8'h2A);
        poke(6, 8'hD6);
        poke(1, 8'h46);  // operand 6
        // floating bus (R2), B captures zero
        beat("float", 7'b0000000, 6'b010000, 0, 0, 0, 8'h00);
        // fetch: PC -> MAR (R1)
        beat("fetch0", 7'b0000001, 6'b000001, 0, 0, 0, 8'h00);
        // RAM -> IR with PC++ on same edge (R5, R9)
        beat("fetch1", 7'b0000100, 6'b000010, 1, 0, 0, 8'h00);
        // IR operand -> MAR (R8)
        beat("operand", 7'b0000010, 6'b000001, 0, 0, 0, 8'h00);
        // RAM -> A (R9)
        beat("lda", 7'b0000100, 6'b001000, 0, 0, 0, 8'h00);
        // second fetch: operand 6 -> B
        beat("fetch0b", 7'b0000001, 6'b000001, 0, 0, 0, 8'h00);
        beat("fetch1b", 7'b0000100, 6'b000010, 1, 0, 0, 8'h00);
        beat("operandb", 7'b0000010, 6'b000001, 0, 0, 0, 8'h00);
        beat("ldb", 7'b0000100, 6'b010000, 0, 0, 0, 8'h00);
        // ALU drives bus, A captures sum, flags load: 0x2A+0xD6 = 0x100 -> zero, carry (R6, R7)
        beat("add wrap", 7'b0100000, 6'b001000, 0, 1, 0, 8'h00);
        // ALU out without flag_ld: flags hold (R7)
        beat("alu noflag", 7'b0100000, 6'b000000, 0, 0, 1, 8'h00);
        // set A and B via external, then subtract with borrow
        beat("multi load", 7'b1000000, 6'b011011, 0, 0, 0, 8'h13); // R4 four loaders
        beat("b=20", 7'b1000000, 6'b010000, 0, 0, 0, 8'h20);
        beat("sub borrow", 7'b0100000, 6'b001000, 0, 1, 1, 8'h00); // R6 R7 0x13-0x20
        beat("b=f3", 7'b1000000, 6'b010000, 0, 0, 0, 8'hF3);
        beat("sub equal", 7'b0100000, 6'b000000, 0, 1, 1, 8'h00); // R7 zero, no borrow
        beat("add small", 7'b0100000, 6'b001000, 0, 1, 0, 8'h00); // R6 0xF3+0xF3
        // contention: PC and A both driving, A captures OR (R3)
        beat("conflict2", 7'b0001001, 6'b001000, 0, 0, 0, 8'h00);
        beat("conflict3", 7'b1011000, 6'b000000, 0, 0, 0, 8'h81);
        // jump wins over increment (R5)
        beat("jump", 7'b1000000, 6'b100000, 1, 0, 0, 8'hFC);
        // wrap 12..15 -> 0 (R5)
        for (int k = 0; k < 5; k++) beat("pc wrap", 7'b0000001, 6'b000000, 1, 0, 0, 8'h00);
        // B drives; store B to RAM at MAR then read back (R9)
        beat("mar=9", 7'b1000000, 6'b000001, 0, 0, 0, 8'h09);
        beat("store b", 7'b0010000, 6'b000100, 0, 0, 0, 8'h00);
        beat("read back", 7'b0000100, 6'b001000, 0, 0, 0, 8'h00);
        // MAR takes low nibble only (R11)
        beat("mar nibble", 7'b1000000, 6'b000001, 0, 0, 0, 8'hB7);
        // reset again: registers clear, RAM kept (R10)
        do_reset();
        beat("mar=9 again", 7'b1000000, 6'b000001, 0, 0, 0, 8'h09);
        beat("ram kept", 7'b0000100, 6'b000000, 0, 0, 0, 8'h00); // R10 RAM survives
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule